// File: doc/BRIEF.md
# Lockable Strap Register Bank

This block keeps the configuration straps of a security controller. Each strap register takes its value from an external strap port at the release of cold reset. After that, firmware may overwrite any strap through a simple single-cycle register bus. It can do so until it sets a fuse-write-done flag. That flag is set-only and freezes the whole bank until the next cold reset. A warm reset does not disturb the straps, the flag or the sampled debug-intent bit. It only resets the bus error flag and the input-change logic.

The block also mirrors a 64-bit group of generic input wires into read-only registers. The mirror is a registered sample of the wires. Any bit that differs between the live wires and the previous clock's sample sets a sticky notification status bit. That bit drives the interrupt line until firmware clears it with a write-one-to-clear. Generic input bits that carry no defined function are expected to be tied to zero by the integrator.

Top module: `strap_lock_bank`

## Requirements
- R1: One clock edge after cold reset is released, every strap register (five 64-bit address straps and six 32-bit word straps) holds its strap port value. Changes on the strap ports after that edge are not reflected in the registers.
- R2: Register map, in word addresses:
  - 0: control, bit 0 = lock flag.
  - 1: interrupt status, bit 0.
  - 2: debug intent, bit 0.
  - 4 and 5: generic input mirror, low word and high word.
  - 16+2i and 17+2i: address strap i, low word and high word.
  - 32+j: word strap j.

  While the bank is unlocked, a strap write takes effect at the clock edge of the write and reads back at once.
- R3: The lock flag resets to 0 on cold reset. Writing 1 to bit 0 of word 0 sets it, and `bankLocked` is high from the next edge. Writing 0 never clears it. Only cold reset clears it.
- R4: A strap write while the lock flag is set leaves the register unchanged. `regErr` is high for the one cycle after that write's edge.
- R5: A warm reset leaves the straps, the lock flag and the debug-intent bit unchanged, and does not reload them from the ports.
- R6: The debug-intent bit is taken from `dbgIntentIn` at the same load edge as the straps. Writes to word 2 have no effect on it.
- R7: Words 4 and 5 read the generic inputs as sampled at the most recent clock edge.
- R8: If the generic inputs at a clock edge differ in any bit from the previous edge's sample, the interrupt status bit and `genIrq` are 1 after that edge. They stay 1 while no clear arrives.
- R9: Writing 1 to bit 0 of word 1 clears the status bit. If a toggle is seen at the same edge, the set wins.
- R10: The first edge after either reset only samples the inputs and raises no interrupt. The status bit reads 0 after warm or cold reset.
- R11: `regErr` stays 0 for writes while unlocked and for writes to non-strap addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| coldRstN | input | 1 | Cold reset, active low, asynchronous assertion |
| warmRstN | input | 1 | Warm reset, active low, asynchronous assertion |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | 6 | Register word address (write and read) |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| regErr | output | 1 | Write to a locked strap was dropped (one cycle) |
| addrStrapIn | input | 320 | Address strap ports, strap i in bits 64i+63:64i |
| wordStrapIn | input | 192 | Word strap ports, strap j in bits 32j+31:32j |
| dbgIntentIn | input | 1 | Debug-intent strap |
| genIn | input | 64 | Generic input wires |
| genIrq | output | 1 | Generic-input change notification |
| bankLocked | output | 1 | Lock flag |

## Verification
The bench walks every strap half-word through load, unlocked write and locked write. A wrong lock gate would show as a changed readback or a missing or extra error pulse. It also checks the pulse length: an error flag held too long would be caught. Warm reset is applied while the strap ports and the intent port carry new values, so a design that reloaded or cleared on warm reset would read back the wrong data. Each of the 64 generic bits is toggled alone, which exposes a dropped bit in the comparison. The bench also holds the inputs steady at a nonzero value across reset release, catching a detector that fires on its own reset sample. A clear is issued in the same cycle as a toggle, catching a design whose clear has priority over the set.

// File: rtl/strap_bank_pkg.sv
package strap_bank_pkg;
  parameter int NUM_ADDR_STRAPS = 5;
  parameter int NUM_WORD_STRAPS = 6;
  parameter int ADDR_STRAP_W    = 64;
  parameter int WORD_W          = 32;
  parameter int GEN_W           = 64;
  parameter int REG_ADDR_W      = 6;

  localparam int HALF_W = ADDR_STRAP_W / 2;

  localparam int A_CTRL      = 0;
  localparam int A_INTR      = 1;
  localparam int A_INTENT    = 2;
  localparam int A_GEN_LO    = 4;
  localparam int A_GEN_HI    = 5;
  localparam int A_ADDR_BASE = 16;
  localparam int A_WORD_BASE = 32;
  localparam int A_ADDR_END  = A_ADDR_BASE + 2 * NUM_ADDR_STRAPS;
  localparam int A_WORD_END  = A_WORD_BASE + NUM_WORD_STRAPS;

  typedef struct packed {
    logic                       loadStraps;
    logic [NUM_ADDR_STRAPS-1:0] wrAddrStrap;
    logic                       wrHigh;
    logic [NUM_WORD_STRAPS-1:0] wrWordStrap;
    logic                       clrIntr;
    logic [WORD_W-1:0]          wrData;
  } strapStrobes_t;
endpackage

// File: rtl/strap_bank_ctrl.sv
module strap_bank_ctrl
  import strap_bank_pkg::*;
(
  input  logic                  clk,
  input  logic                  coldRstN,
  input  logic                  warmDomRstN,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0]     regWrData,
  output strapStrobes_t         strobes,
  output logic                  locked,
  output logic                  regErr
);
  logic                       loadPending;
  logic                       wrLive;
  logic [NUM_ADDR_STRAPS-1:0] addrHits;
  logic [NUM_WORD_STRAPS-1:0] wordHits;
  logic                       isStrap;

  // one load cycle right after cold reset release
  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN) loadPending <= 1'b1;
    else           loadPending <= 1'b0;
  end

  assign wrLive = regWrEn && !loadPending;

  always_comb begin
    for (int i = 0; i < NUM_ADDR_STRAPS; i++)
      addrHits[i] = (regAddr[REG_ADDR_W-1:1] == (REG_ADDR_W-1)'((A_ADDR_BASE >> 1) + i));
    for (int j = 0; j < NUM_WORD_STRAPS; j++)
      wordHits[j] = (regAddr == REG_ADDR_W'(A_WORD_BASE + j));
  end

  assign isStrap = (|addrHits) || (|wordHits);

  // set-only lock, cleared by cold reset alone
  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN)
      locked <= 1'b0;
    else if (wrLive && regAddr == REG_ADDR_W'(A_CTRL) && regWrData[0])
      locked <= 1'b1;
  end

  always_ff @(posedge clk or negedge warmDomRstN) begin
    if (!warmDomRstN) regErr <= 1'b0;
    else              regErr <= wrLive && locked && isStrap;
  end

  always_comb begin
    strobes.loadStraps  = loadPending;
    strobes.wrAddrStrap = (wrLive && !locked) ? addrHits : '0;
    strobes.wrWordStrap = (wrLive && !locked) ? wordHits : '0;
    strobes.wrHigh      = regAddr[0];
    strobes.clrIntr     = wrLive && regAddr == REG_ADDR_W'(A_INTR) && regWrData[0];
    strobes.wrData      = regWrData;
  end
endmodule

// File: rtl/strap_bank_dp.sv
module strap_bank_dp
  import strap_bank_pkg::*;
(
  input  logic                                    clk,
  input  logic                                    coldRstN,
  input  logic                                    warmDomRstN,
  input  strapStrobes_t                           strobes,
  input  logic [NUM_ADDR_STRAPS*ADDR_STRAP_W-1:0] addrStrapIn,
  input  logic [NUM_WORD_STRAPS*WORD_W-1:0]       wordStrapIn,
  input  logic                                    dbgIntentIn,
  input  logic [GEN_W-1:0]                        genIn,
  input  logic                                    locked,
  input  logic [REG_ADDR_W-1:0]                   regAddr,
  output logic [WORD_W-1:0]                       rdData,
  output logic                                    genIrq
);
  logic [NUM_ADDR_STRAPS-1:0][ADDR_STRAP_W-1:0] addrQ;
  logic [NUM_WORD_STRAPS-1:0][WORD_W-1:0]       wordQ;
  logic                                         intentQ;
  logic [GEN_W-1:0]                             genMirror;
  logic                                         primed;
  logic                                         intrQ;
  logic                                         toggleSeen;

  // cold-domain strap storage
  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN) begin
      addrQ   <= '0;
      wordQ   <= '0;
      intentQ <= 1'b0;
    end else if (strobes.loadStraps) begin
      addrQ   <= addrStrapIn;
      wordQ   <= wordStrapIn;
      intentQ <= dbgIntentIn;
    end else begin
      for (int i = 0; i < NUM_ADDR_STRAPS; i++) begin
        if (strobes.wrAddrStrap[i]) begin
          if (strobes.wrHigh) addrQ[i][ADDR_STRAP_W-1:HALF_W] <= strobes.wrData;
          else                addrQ[i][HALF_W-1:0]            <= strobes.wrData;
        end
      end
      for (int j = 0; j < NUM_WORD_STRAPS; j++)
        if (strobes.wrWordStrap[j]) wordQ[j] <= strobes.wrData;
    end
  end

  // warm-domain change detector
  assign toggleSeen = primed && (genIn != genMirror);

  always_ff @(posedge clk or negedge warmDomRstN) begin
    if (!warmDomRstN) begin
      genMirror <= '0;
      primed    <= 1'b0;
      intrQ     <= 1'b0;
    end else begin
      genMirror <= genIn;
      primed    <= 1'b1;
      if (toggleSeen)            intrQ <= 1'b1;
      else if (strobes.clrIntr)  intrQ <= 1'b0;
    end
  end

  assign genIrq = intrQ;

  always_comb begin
    rdData = '0;
    if (regAddr == REG_ADDR_W'(A_CTRL))   rdData = WORD_W'(locked);
    if (regAddr == REG_ADDR_W'(A_INTR))   rdData = WORD_W'(intrQ);
    if (regAddr == REG_ADDR_W'(A_INTENT)) rdData = WORD_W'(intentQ);
    if (regAddr == REG_ADDR_W'(A_GEN_LO)) rdData = genMirror[WORD_W-1:0];
    if (regAddr == REG_ADDR_W'(A_GEN_HI)) rdData = genMirror[GEN_W-1:WORD_W];
    for (int i = 0; i < NUM_ADDR_STRAPS; i++) begin
      if (regAddr == REG_ADDR_W'(A_ADDR_BASE + 2 * i))     rdData = addrQ[i][HALF_W-1:0];
      if (regAddr == REG_ADDR_W'(A_ADDR_BASE + 2 * i + 1)) rdData = addrQ[i][ADDR_STRAP_W-1:HALF_W];
    end
    for (int j = 0; j < NUM_WORD_STRAPS; j++)
      if (regAddr == REG_ADDR_W'(A_WORD_BASE + j)) rdData = wordQ[j];
  end
endmodule

// File: rtl/strap_lock_bank.sv
module strap_lock_bank
  import strap_bank_pkg::*;
(
  input  logic                                    clk,
  input  logic                                    coldRstN,
  input  logic                                    warmRstN,
  input  logic                                    regWrEn,
  input  logic [REG_ADDR_W-1:0]                   regAddr,
  input  logic [WORD_W-1:0]                       regWrData,
  output logic [WORD_W-1:0]                       regRdData,
  output logic                                    regErr,
  input  logic [NUM_ADDR_STRAPS*ADDR_STRAP_W-1:0] addrStrapIn,
  input  logic [NUM_WORD_STRAPS*WORD_W-1:0]       wordStrapIn,
  input  logic                                    dbgIntentIn,
  input  logic [GEN_W-1:0]                        genIn,
  output logic                                    genIrq,
  output logic                                    bankLocked
);
  logic          warmDomRstN;
  strapStrobes_t strobes;

  assign warmDomRstN = coldRstN & warmRstN;

  strap_bank_ctrl u_ctrl (
    .clk        (clk),
    .coldRstN   (coldRstN),
    .warmDomRstN(warmDomRstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .strobes    (strobes),
    .locked     (bankLocked),
    .regErr     (regErr)
  );

  strap_bank_dp u_dp (
    .clk        (clk),
    .coldRstN   (coldRstN),
    .warmDomRstN(warmDomRstN),
    .strobes    (strobes),
    .addrStrapIn(addrStrapIn),
    .wordStrapIn(wordStrapIn),
    .dbgIntentIn(dbgIntentIn),
    .genIn      (genIn),
    .locked     (bankLocked),
    .regAddr    (regAddr),
    .rdData     (regRdData),
    .genIrq     (genIrq)
  );
endmodule

// File: rtl/strap_bank_chk.sv
module strap_bank_chk
  import strap_bank_pkg::*;
(
  input logic                  clk,
  input logic                  coldRstN,
  input logic                  warmRstN,
  input logic                  regWrEn,
  input logic [REG_ADDR_W-1:0] regAddr,
  input logic [WORD_W-1:0]     regWrData,
  input logic [WORD_W-1:0]     regRdData,
  input logic                  regErr,
  input logic                  bankLocked,
  input logic                  genIrq
);
  logic inStrapRange;
  assign inStrapRange = (int'(regAddr) >= A_ADDR_BASE && int'(regAddr) < A_ADDR_END) ||
                        (int'(regAddr) >= A_WORD_BASE && int'(regAddr) < A_WORD_END);

  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!coldRstN)
    bankLocked |=> bankLocked);

  a_r4_err_needs_locked_write: assert property (@(posedge clk) disable iff (!coldRstN || !warmRstN)
    regErr |-> $past(regWrEn && bankLocked));

  a_r4_locked_straps_frozen: assert property (@(posedge clk) disable iff (!coldRstN)
    (bankLocked && $past(bankLocked) && $stable(regAddr) && inStrapRange) |-> $stable(regRdData));

  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!coldRstN || !warmRstN)
    (genIrq && !(regWrEn && regAddr == REG_ADDR_W'(A_INTR) && regWrData[0])) |=> genIrq);

  a_r11_no_err_unmapped: assert property (@(posedge clk) disable iff (!coldRstN || !warmRstN)
    (regWrEn && !inStrapRange) |=> !regErr);
endmodule

bind strap_lock_bank strap_bank_chk u_chk (.*);

// File: tb/strap_lock_bank_tb.sv
module strap_lock_bank_tb;
  import strap_bank_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic                                    coldRstN, warmRstN, regWrEn, regErr;
  logic [REG_ADDR_W-1:0]                   regAddr;
  logic [WORD_W-1:0]                       regWrData, regRdData;
  logic [NUM_ADDR_STRAPS*ADDR_STRAP_W-1:0] addrStrapIn;
  logic [NUM_WORD_STRAPS*WORD_W-1:0]       wordStrapIn;
  logic                                    dbgIntentIn, genIrq, bankLocked;
  logic [GEN_W-1:0]                        genIn;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  strap_lock_bank u_dut (.*);

  function automatic logic [63:0] addrPat(int i, int k);
    return {32'hA000_0000 + 32'(i * 16 + k), 32'h5000_0000 + 32'(i * 256 + k * 7)};
  endfunction
  function automatic logic [31:0] wordPat(int j, int k);
    return 32'hC0DE_0000 ^ 32'(j << 8) ^ 32'(k * 3 + 1);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rdReg(input int a, output logic [31:0] v);
    regAddr = REG_ADDR_W'(a);
    #1;
    v = regRdData;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    regWrEn = 1'b1;
    regAddr = REG_ADDR_W'(a);
    regWrData = d;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic setPorts(input int k);
    for (int i = 0; i < NUM_ADDR_STRAPS; i++) addrStrapIn[i*64 +: 64] = addrPat(i, k);
    for (int j = 0; j < NUM_WORD_STRAPS; j++) wordStrapIn[j*32 +: 32] = wordPat(j, k);
  endtask

  task automatic checkStraps(input string tag, input int k);
    logic [31:0] v;
    for (int i = 0; i < NUM_ADDR_STRAPS; i++) begin
      logic [63:0] e;
      e = addrPat(i, k);
      rdReg(A_ADDR_BASE + 2 * i, v);
      check(tag, 64'(v), 64'(e[31:0]));
      rdReg(A_ADDR_BASE + 2 * i + 1, v);
      check(tag, 64'(v), 64'(e[63:32]));
    end
    for (int j = 0; j < NUM_WORD_STRAPS; j++) begin
      rdReg(A_WORD_BASE + j, v);
      check(tag, 64'(v), 64'(wordPat(j, k)));
    end
  endtask

  task automatic checkMirror(input string tag);
    logic [31:0] lo, hi;
    rdReg(A_GEN_LO, lo);
    rdReg(A_GEN_HI, hi);
    check(tag, {hi, lo}, genIn);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    coldRstN = 1'b0; warmRstN = 1'b1; regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    dbgIntentIn = 1'b1; genIn = 64'h0123_4567_89AB_CDEF;
    setPorts(1);
    repeat (3) tick();
    coldRstN = 1'b1;
    // reset state before the load edge
    check("R3 lock after cold reset", 64'(bankLocked), 64'd0);
    check("R10 irq after cold reset", 64'(genIrq), 64'd0);
    check("R11 err after reset", 64'(regErr), 64'd0);
    tick();
    checkStraps("R1 cold load", 1);
    rdReg(A_INTENT, v);
    check("R6 intent sampled", 64'(v), 64'd1);
    check("R10 no irq on priming edge", 64'(genIrq), 64'd0);
    checkMirror("R7 mirror after reset");
    // ports change after load: no effect
    setPorts(2);
    tick();
    checkStraps("R1 no reload after load", 1);

    // unlocked writes
    for (int i = 0; i < NUM_ADDR_STRAPS; i++) begin
      logic [63:0] e;
      e = addrPat(i, 3);
      wr(A_ADDR_BASE + 2 * i, e[31:0]);
      check("R11 no err unlocked", 64'(regErr), 64'd0);
      wr(A_ADDR_BASE + 2 * i + 1, e[63:32]);
      check("R11 no err unlocked", 64'(regErr), 64'd0);
    end
    for (int j = 0; j < NUM_WORD_STRAPS; j++) begin
      wr(A_WORD_BASE + j, wordPat(j, 3));
      check("R11 no err unlocked", 64'(regErr), 64'd0);
    end
    checkStraps("R2 unlocked write", 3);
    wr(48, 32'hFFFF_FFFF);
    check("R11 no err unmapped", 64'(regErr), 64'd0);
    wr(A_INTENT, 32'h0);
    check("R11 no err intent write", 64'(regErr), 64'd0);
    rdReg(A_INTENT, v);
    check("R6 intent read-only", 64'(v), 64'd1);

    // lock
    wr(A_CTRL, 32'h0);
    check("R3 write 0 does not lock", 64'(bankLocked), 64'd0);
    wr(A_CTRL, 32'h1);
    check("R3 lock set", 64'(bankLocked), 64'd1);
    rdReg(A_CTRL, v);
    check("R3 lock readback", 64'(v), 64'd1);

    // locked writes
    for (int a = A_ADDR_BASE; a < A_ADDR_END; a++) begin
      wr(a, 32'hDEAD_0000 + 32'(a));
      check("R4 err pulse", 64'(regErr), 64'd1);
      tick();
      check("R4 err one cycle", 64'(regErr), 64'd0);
    end
    for (int a = A_WORD_BASE; a < A_WORD_END; a++) begin
      wr(a, 32'hBEEF_0000 + 32'(a));
      check("R4 err pulse", 64'(regErr), 64'd1);
      tick();
      check("R4 err one cycle", 64'(regErr), 64'd0);
    end
    checkStraps("R4 locked write dropped", 3);
    wr(A_CTRL, 32'h0);
    check("R3 lock not clearable", 64'(bankLocked), 64'd1);

    // generic input sweep
    for (int b = 0; b < GEN_W; b++) begin
      wr(A_INTR, 32'h1);
      check("R9 w1c clears", 64'(genIrq), 64'd0);
      genIn = genIn ^ (64'd1 << b);
      tick();
      check("R8 toggle sets irq", 64'(genIrq), 64'd1);
      checkMirror("R7 mirror tracks input");
    end
    wr(A_INTR, 32'h0);
    check("R8 w0 keeps irq", 64'(genIrq), 64'd1);
    wr(A_INTR, 32'h1);
    repeat (3) tick();
    check("R8 steady input no irq", 64'(genIrq), 64'd0);
    genIn = genIn ^ 64'h8000_0000_0000_0005;
    wr(A_INTR, 32'h1);
    check("R9 set wins over clear", 64'(genIrq), 64'd1);
    rdReg(A_INTR, v);
    check("R9 status readback", 64'(v), 64'd1);

    // warm reset with new port values
    setPorts(4);
    dbgIntentIn = 1'b0;
    warmRstN = 1'b0;
    tick();
    check("R10 irq cleared by warm reset", 64'(genIrq), 64'd0);
    warmRstN = 1'b1;
    tick();
    check("R10 no irq on warm priming edge", 64'(genIrq), 64'd0);
    check("R5 lock survives warm reset", 64'(bankLocked), 64'd1);
    checkStraps("R5 straps survive warm reset", 3);
    rdReg(A_INTENT, v);
    check("R5 intent survives warm reset", 64'(v), 64'd1);
    checkMirror("R7 mirror after warm reset");

    // cold reset reloads
    coldRstN = 1'b0;
    tick();
    coldRstN = 1'b1;
    tick();
    checkStraps("R1 cold reload", 4);
    check("R3 lock cleared by cold reset", 64'(bankLocked), 64'd0);
    rdReg(A_INTENT, v);
    check("R6 intent resampled", 64'(v), 64'd0);
    check("R10 no irq after cold reset", 64'(genIrq), 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule